// File: doc/BRIEF.md
# Power-Monitor Two-Wire Target Interface

This block is the serial target that sits between a two-wire I2C bus (fast mode, up to 400 kHz) and the measurement core of a current and voltage monitor. It oversamples the bus on the system clock and detects bus conditions itself. On the write side it loads a seven-bit command word, or writes one of three extended configuration registers, and hands all of them to the conversion sequencer and the alert logic. On the read side it returns packed 12-bit conversion codes, or a single status byte.

The bus clock and data pins enter through synchronizers. The data pin is driven only as an output enable that pulls the line low. The target address is a fixed five-bit prefix followed by two bits taken from a strap input.

Read data is captured at the address phase, so the bytes of one transaction always come from one consistent set of codes. The command output is a valid-only stream: `cmd_valid` pulses for one cycle with each new command word. There is no ready signal, because the bus cannot be stalled. The sequencer must accept the word in the cycle it appears.

Top module: `pmon_i2c_target`

## Requirements
- R1: The target acknowledges only the 7-bit address {ADDR_PREFIX, addr_strap} (default prefix 5'b11010, so 0x68 to 0x6B). Any other address receives no acknowledge and changes no register.
- R2: The target acknowledges by pulling SDA low during the ninth clock of a byte. It changes its SDA drive only while SCL is low.
- R3: An address with the write bit (0), followed directly by a stop, is acknowledged and leaves every register unchanged. No `cmd_valid` pulse is produced.
- R4: When the first write byte has bit 7 = 0, its bits 6:0 load `cmd_q`, and `cmd_valid` is high for exactly one cycle.
- R5: When the first write byte has bit 7 = 1, it is an extended selector. Its bits 1:0 choose the register that the next byte writes: 01 = `alert_en_q`, 10 = `thresh_q`, 11 = `ctrl_q`. Selector 00 writes nothing.
- R6: Voltage is enabled when command bit 0 or bit 1 is set. Current is enabled when bit 2 or bit 3 is set. With both enabled, a read returns three bytes: volt[11:4], then curr[11:4], then {volt[3:0], curr[3:0]}.
- R7: With one channel enabled, a read returns two bytes: code[11:4], then {code[3:0], 4'b0000}. When current is not enabled, the voltage channel is returned.
- R8: When command bit 6 is set, a read returns `status_in` as a single byte. This takes priority over conversion data.
- R9: A master NACK ends the read. The target releases SDA and drives nothing more until a new start.
- R10: While `oneshot_busy` is high, an address with the read bit is not acknowledged.
- R11: A repeated start, without a stop before it, restarts address decoding. The next write byte is again treated as the first byte.
- R12: Read data is captured when the read address is accepted. Code changes later in the same transaction do not affect the returned bytes.
- R13: After reset: `cmd_q` = 0, `alert_en_q` = 8'h04, `thresh_q` = 8'hFF, `ctrl_q` = 0, `sda_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level |
| sda_oe | output | 1 | High to pull SDA low |
| addr_strap | input | 2 | Low two address bits |
| volt_code | input | 12 | Latest voltage conversion code |
| curr_code | input | 12 | Latest current conversion code |
| status_in | input | 8 | Status byte from the alert logic |
| oneshot_busy | input | 1 | A one-shot conversion is pending |
| cmd_q | output | 7 | Command word |
| cmd_valid | output | 1 | One-cycle pulse when `cmd_q` is loaded |
| alert_en_q | output | 8 | Alert-enable register |
| thresh_q | output | 8 | Alert threshold register |
| ctrl_q | output | 8 | Control register |

## Verification
The bench targets the cases where a decoder tends to go wrong, one per design fault:

- **First-byte decode.** A selector byte with bit 7 = 1 followed by a repeated start must not make the next write land in the threshold register. A design that keeps its byte index across the repeated start would write there.
- **Quick command.** An address-only write must leave every register alone and produce no command pulse.
- **Read length and packing.** These change with the command bits, so all three packings and the status byte are read. A wrong nibble order or a missing zero pad shows up as a byte mismatch.
- **Captured read data.** The conversion codes change after the read address, and the bytes must still match the old codes.
- **Busy and NACK.** A busy one-shot must refuse a read address. After a master NACK, SDA must stay released, so a further byte of clocks reads as all ones.

// File: rtl/pmon_i2c_pkg.sv
package pmon_i2c_pkg;
  localparam int CODE_W = 12;
  localparam int LO_W   = CODE_W - 8;
  // command word bit positions
  localparam int CB_VCONT = 0;
  localparam int CB_VONCE = 1;
  localparam int CB_ICONT = 2;
  localparam int CB_IONCE = 3;
  localparam int CB_STAT  = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } tgt_state_e;

  typedef enum logic [1:0] { RM_VOLT, RM_CURR, RM_BOTH, RM_STAT } rd_mode_e;

  function automatic rd_mode_e mode_of(input logic [6:0] c);
    logic v_on, i_on;
    v_on = c[CB_VCONT] | c[CB_VONCE];
    i_on = c[CB_ICONT] | c[CB_IONCE];
    if (c[CB_STAT])     return RM_STAT;
    else if (v_on && i_on) return RM_BOTH;
    else if (i_on)      return RM_CURR;
    else                return RM_VOLT;
  endfunction
endpackage

// File: rtl/pmon_i2c_sync.sv
module pmon_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  localparam int NLINES = 2;
  logic [NLINES-1:0] raw, synced, prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain   <= '1;
        prev[g] <= 1'b1;
      end else begin
        chain   <= {chain[STAGES-2:0], raw[g]};
        prev[g] <= chain[STAGES-1];
      end
    end
    assign synced[g] = chain[STAGES-1];
  end

  logic scl_s, scl_d, sda_d;
  assign scl_s = synced[0];
  assign sda_s = synced[1];
  assign scl_d = prev[0];
  assign sda_d = prev[1];

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/pmon_i2c_pack.sv
module pmon_i2c_pack
  import pmon_i2c_pkg::*;
(
  input  rd_mode_e          mode,
  input  logic [CODE_W-1:0] volt,
  input  logic [CODE_W-1:0] curr,
  input  logic [7:0]        stat,
  input  logic [1:0]        idx,
  output logic [7:0]        byte_o
);
  logic [7:0] v_hi, c_hi, v_lo, c_lo, mix;
  assign v_hi = volt[CODE_W-1:LO_W];
  assign c_hi = curr[CODE_W-1:LO_W];
  assign v_lo = {volt[LO_W-1:0], {(8-LO_W){1'b0}}};
  assign c_lo = {curr[LO_W-1:0], {(8-LO_W){1'b0}}};
  assign mix  = {volt[LO_W-1:0], curr[LO_W-1:0]};

  always_comb begin
    byte_o = 8'hFF;
    unique case (mode)
      RM_BOTH: case (idx)
                 2'd0: byte_o = v_hi;
                 2'd1: byte_o = c_hi;
                 2'd2: byte_o = mix;
                 default: byte_o = 8'hFF;
               endcase
      RM_VOLT: if (idx == 2'd0) byte_o = v_hi; else if (idx == 2'd1) byte_o = v_lo;
      RM_CURR: if (idx == 2'd0) byte_o = c_hi; else if (idx == 2'd1) byte_o = c_lo;
      RM_STAT: if (idx == 2'd0) byte_o = stat;
      default: byte_o = 8'hFF;
    endcase
  end
endmodule

// File: rtl/pmon_i2c_target.sv
module pmon_i2c_target
  import pmon_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX  = 5'b11010,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [7:0] ALERT_EN_RST = 8'h04,
  parameter logic [7:0] THRESH_RST   = 8'hFF,
  parameter logic [7:0] CTRL_RST     = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_strap,
  input  logic [CODE_W-1:0] volt_code,
  input  logic [CODE_W-1:0] curr_code,
  input  logic [7:0]        status_in,
  input  logic              oneshot_busy,
  output logic [6:0]        cmd_q,
  output logic              cmd_valid,
  output logic [7:0]        alert_en_q,
  output logic [7:0]        thresh_q,
  output logic [7:0]        ctrl_q
);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  logic sda_s, scl_rise, scl_fall, start_p, stop_p;

  pmon_i2c_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  tgt_state_e        state;
  logic [3:0]        bitcnt;
  logic [7:0]        sreg, tx;
  logic              is_rd;
  logic [1:0]        wr_idx, ext_sel, rd_idx;
  logic [CODE_W-1:0] snap_v, snap_c;
  logic [7:0]        snap_s, pk_byte;
  rd_mode_e          snap_m;

  pmon_i2c_pack i_pack (
    .mode(snap_m), .volt(snap_v), .curr(snap_c), .stat(snap_s),
    .idx(rd_idx), .byte_o(pk_byte)
  );

  logic addr_hit, take_bit, full;
  assign addr_hit = (sreg[7:1] == {ADDR_PREFIX, addr_strap}) && !(sreg[0] && oneshot_busy);
  assign take_bit = scl_rise && (bitcnt < BYTE_BITS);
  assign full     = (bitcnt == BYTE_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  bitcnt <= '0;  sreg <= '0;  tx <= '1;
      is_rd <= 1'b0;  wr_idx <= '0;  ext_sel <= '0;  rd_idx <= '0;
      sda_oe <= 1'b0;  cmd_q <= '0;  cmd_valid <= 1'b0;
      alert_en_q <= ALERT_EN_RST;  thresh_q <= THRESH_RST;  ctrl_q <= CTRL_RST;
      snap_v <= '0;  snap_c <= '0;  snap_s <= '0;  snap_m <= RM_VOLT;
    end else begin
      cmd_valid <= 1'b0;
      if (stop_p) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_p) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (take_bit) begin
              sreg   <= {sreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end
            if (scl_fall && full) begin
              if (addr_hit) begin
                sda_oe <= 1'b1;
                state  <= ST_AACK;
                is_rd  <= sreg[0];
                rd_idx <= '0;
                if (sreg[0]) begin
                  snap_v <= volt_code;
                  snap_c <= curr_code;
                  snap_s <= status_in;
                  snap_m <= mode_of(cmd_q);
                end
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            bitcnt <= '0;
            if (is_rd) begin
              sda_oe <= ~pk_byte[7];
              tx     <= {pk_byte[6:0], 1'b1};
              state  <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              wr_idx <= '0;
              state  <= ST_WR;
            end
          end
          ST_WR: begin
            if (take_bit) begin
              sreg   <= {sreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end
            if (scl_fall && full) begin
              sda_oe <= 1'b1;
              state  <= ST_WACK;
              if (wr_idx != 2'd3) wr_idx <= wr_idx + 2'd1;
              if (wr_idx == 2'd0) begin
                if (!sreg[7]) begin
                  cmd_q     <= sreg[6:0];
                  cmd_valid <= 1'b1;
                  ext_sel   <= '0;
                end else begin
                  ext_sel <= sreg[1:0];
                end
              end else if (wr_idx == 2'd1) begin
                case (ext_sel)
                  2'd1: alert_en_q <= sreg;
                  2'd2: thresh_q   <= sreg;
                  2'd3: ctrl_q     <= sreg;
                  default: ;
                endcase
              end
            end
          end
          ST_WACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_WR;
          end
          ST_RD: begin
            if (take_bit) bitcnt <= bitcnt + 4'd1;
            if (scl_fall) begin
              if (full) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~tx[7];
                tx     <= {tx[6:0], 1'b1};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_s) state <= ST_IDLE;
              else if (rd_idx != 2'd3) rd_idx <= rd_idx + 2'd1;
            end else if (scl_fall) begin
              bitcnt <= '0;
              sda_oe <= ~pk_byte[7];
              tx     <= {pk_byte[6:0], 1'b1};
              state  <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pmon_i2c_chk.sv
module pmon_i2c_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic [6:0] cmd_q,
  input logic       cmd_valid,
  input logic [7:0] alert_en_q,
  input logic [7:0] thresh_q,
  input logic [7:0] ctrl_q
);
  // R2: drive on SDA only moves while the bus clock is low
  a_r2_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R4: command strobe lasts one cycle
  a_r4_cmd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R4: command word moves only together with its strobe
  a_r4_cmd_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_q) |-> cmd_valid);

  // R5: extended registers change apart from command loads, with SCL low
  a_r5_ext_write_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(alert_en_q) || !$stable(thresh_q) || !$stable(ctrl_q))
      |-> (!cmd_valid && !scl_i));
endmodule

bind pmon_i2c_target pmon_i2c_chk i_chk (.*);

// File: tb/test_pmon_i2c_target.sv
module test_pmon_i2c_target;
  localparam int Q = 8;  // system clocks per quarter bus bit

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic [11:0] volt = 12'h000, curr = 12'h000;
  logic [7:0] stat = 8'h00;
  logic busy = 1'b0;
  logic sda_oe, cmd_valid;
  logic [6:0] cmd_q;
  logic [7:0] alert_en_q, thresh_q, ctrl_q;
  wire sda_line = sda_m & ~sda_oe;

  int n_checks = 0, n_fail = 0, n_valid = 0;
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmon_i2c_target i_pmon_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_strap(strap), .volt_code(volt), .curr_code(curr), .status_in(stat),
    .oneshot_busy(busy), .cmd_q(cmd_q), .cmd_valid(cmd_valid),
    .alert_en_q(alert_en_q), .thresh_q(thresh_q), .ctrl_q(ctrl_q)
  );

  always @(posedge clk) if (rst_n && cmd_valid) n_valid++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor: pairs each read byte with the next expected one
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        logic [7:0] a;
        a = act_q.pop_front();
        if (exp_q.size() == 0) chk(1'b0, "unexpected read byte", a, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(a == e, t, a, e);
        end
      end
    end
  end

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; tick(Q);
    scl = 1'b1; tick(Q);
    r = sda_line; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      v[i] = r;
    end
    clk_bit(~give_ack, r);
  endtask

  task automatic write_regs(input logic [7:0] b0, input logic [7:0] b1, input int nb, input string req);
    logic ack;
    i2c_start();
    wr_byte(8'hD4, ack);
    chk(ack, req, ack, 1);
    if (nb > 0) begin wr_byte(b0, ack); chk(ack, req, ack, 1); end
    if (nb > 1) begin wr_byte(b1, ack); chk(ack, req, ack, 1); end
    i2c_stop();
  endtask

  task automatic read_txn(input int n, input string req);
    logic ack;
    logic [7:0] v;
    i2c_start();
    wr_byte(8'hD5, ack);
    chk(ack, req, ack, 1);
    for (int k = 0; k < n; k++) begin
      rd_byte(k != n - 1, v);
      act_q.push_back(v);
    end
    i2c_stop();
  endtask

  task automatic finish_run();
    tick(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      finish_run();
    end
  end

  initial begin
    logic ack;
    logic [7:0] v;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    // R13 reset values
    chk(cmd_q == 7'h00, "R13 cmd_q", cmd_q, 0);
    chk(alert_en_q == 8'h04, "R13 alert_en_q", alert_en_q, 8'h04);
    chk(thresh_q == 8'hFF, "R13 thresh_q", thresh_q, 8'hFF);
    chk(ctrl_q == 8'h00, "R13 ctrl_q", ctrl_q, 0);
    chk(sda_oe == 1'b0, "R13 sda_oe", sda_oe, 0);

    // R1: foreign address (0x6B) gets no acknowledge and writes nothing
    i2c_start();
    wr_byte(8'hD6, ack);
    chk(!ack, "R1 foreign address acked", ack, 0);
    wr_byte(8'h82, ack);
    wr_byte(8'h11, ack);
    i2c_stop();
    chk(thresh_q == 8'hFF, "R1 foreign write landed", thresh_q, 8'hFF);

    // R3: quick command
    write_regs(8'h00, 8'h00, 0, "R3 quick ack");
    chk(n_valid == 0, "R3 quick command pulsed", n_valid, 0);
    chk(cmd_q == 7'h00, "R3 cmd changed", cmd_q, 0);

    // R4: command byte
    write_regs(8'h05, 8'h00, 1, "R4 cmd ack");
    chk(cmd_q == 7'h05, "R4 cmd_q", cmd_q, 5);
    chk(n_valid == 1, "R4 cmd_valid count", n_valid, 1);

    // R5: extended writes
    write_regs(8'h82, 8'h5A, 2, "R5 ack");
    chk(thresh_q == 8'h5A, "R5 thresh", thresh_q, 8'h5A);
    write_regs(8'h81, 8'h33, 2, "R5 ack");
    chk(alert_en_q == 8'h33, "R5 alert_en", alert_en_q, 8'h33);
    write_regs(8'h83, 8'h01, 2, "R5 ack");
    chk(ctrl_q == 8'h01, "R5 ctrl", ctrl_q, 1);
    write_regs(8'h80, 8'h77, 2, "R5 ack");
    chk(thresh_q == 8'h5A && alert_en_q == 8'h33 && ctrl_q == 8'h01,
        "R5 selector 00 wrote", {alert_en_q, thresh_q, ctrl_q}, 24'h335A01);
    chk(cmd_q == 7'h05 && n_valid == 1, "R5 ext write touched cmd", n_valid, 1);

    // R6: both channels
    volt = 12'hABC; curr = 12'h123;
    expect_byte(8'hAB, "R6 byte0"); expect_byte(8'h12, "R6 byte1"); expect_byte(8'hC3, "R6 byte2");
    read_txn(3, "R6 addr ack");

    // R7: single channel, voltage then current
    write_regs(8'h02, 8'h00, 1, "R7 cmd ack");
    expect_byte(8'hAB, "R7 volt hi"); expect_byte(8'hC0, "R7 volt lo");
    read_txn(2, "R7 addr ack");
    write_regs(8'h08, 8'h00, 1, "R7 cmd ack");
    expect_byte(8'h12, "R7 curr hi"); expect_byte(8'h30, "R7 curr lo");
    read_txn(2, "R7 addr ack");

    // R10: busy one-shot refuses the read address
    busy = 1'b1;
    i2c_start();
    wr_byte(8'hD5, ack);
    chk(!ack, "R10 read acked while busy", ack, 0);
    i2c_stop();
    busy = 1'b0;

    // R8: status read has priority
    stat = 8'h2D;
    write_regs(8'h45, 8'h00, 1, "R8 cmd ack");
    expect_byte(8'h2D, "R8 status");
    read_txn(1, "R8 addr ack");

    // R9: after NACK the target stays off the line
    i2c_start();
    wr_byte(8'hD5, ack);
    chk(ack, "R9 addr ack", ack, 1);
    rd_byte(1'b0, v);
    chk(v == 8'h2D, "R9 first byte", v, 8'h2D);
    rd_byte(1'b0, v);
    chk(v == 8'hFF, "R9 line driven after NACK", v, 8'hFF);
    i2c_stop();

    // R11: repeated start restarts the first-byte decode
    write_regs(8'h05, 8'h00, 1, "R11 cmd ack");
    i2c_start();
    wr_byte(8'hD4, ack);
    wr_byte(8'h82, ack);
    i2c_start();
    wr_byte(8'hD4, ack);
    chk(ack, "R11 addr after restart", ack, 1);
    wr_byte(8'h04, ack);
    i2c_stop();
    chk(cmd_q == 7'h04, "R11 command after restart", cmd_q, 4);
    chk(thresh_q == 8'h5A, "R11 threshold written", thresh_q, 8'h5A);

    // R12: codes captured at address phase
    write_regs(8'h05, 8'h00, 1, "R12 cmd ack");
    volt = 12'h9F1; curr = 12'h4E7;
    expect_byte(8'h9F, "R12 byte0"); expect_byte(8'h4E, "R12 byte1"); expect_byte(8'h17, "R12 byte2");
    i2c_start();
    wr_byte(8'hD5, ack);
    chk(ack, "R12 addr ack", ack, 1);
    volt = 12'h000; curr = 12'hFFF;
    for (int k = 0; k < 3; k++) begin
      rd_byte(k != 2, v);
      act_q.push_back(v);
    end
    i2c_stop();

    tick(4);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule